// File: doc/BRIEF.md
# Lockable Watchdog Timer with Prescaled Count Clock

This block supervises software by counting prescaled system-clock ticks and raising a one-cycle reset request when the software fails to restart it in time. A free-running 8-bit low count advances on every tick. An 8-bit reload value says how many whole 256-tick periods are added on top of the part of the current period still left. Software restarts the timeout with a kick strobe. At that moment the remaining time is recomputed from the reload value and from the low count as it stands.

A configuration write carries an enable bit, a sticky lock bit, a two-bit count-clock select and an idle-freeze select. The watchdog runs whenever enable or lock is set. Once lock is set, only a system reset clears it. The clock select and the idle-freeze select stay fixed while the watchdog runs, so a runaway program cannot slow the watchdog down. The block leaves reset already running, with the slowest clock and a timeout of 256 ticks.

The asynchronous active-low reset is released through a two-stage synchroniser. Internal logic therefore leaves reset on the second rising clock edge after `rst_ni` goes high.

Top module: `wdog_lock_top`

## Requirements
- R1: While reset is held and just after it is released, running_o=1, lock_o=0, clksel_o=0, idlesel_o=0, low_byte_o=0 and reset_req_o=0.
- R2: With no writes and no kick after reset, reset_req_o is first seen high after exactly 3074 rising edges counted from the edge where rst_ni goes high. This is 2 synchroniser edges plus 256 ticks of system clock / 12.
- R3: A kick taken at a clock edge re-arms the timeout to T = 256*reload + (256 - L) ticks, where L is low_byte_o at that edge. With clksel=2, reset_req_o goes high after the T-th rising edge following the kick edge.
- R4: A watchdog kicked more often than its timeout never raises reset_req_o.
- R5: running_o = enable OR lock. With lock clear, writing enable=0 stops the timeout (no reset_req_o), while low_byte_o keeps advancing.
- R6: Once a write sets lock, lock_o and running_o stay 1 through any later write until reset, including writes with enable=0 and lock=0.
- R7: Writes to the clock select and the idle-freeze select take effect only when running_o is 0 at the write; otherwise they are ignored.
- R8: Clock select encoding: 0 = system clock / 12, 1 = / 4, 2 and 3 = system clock. low_byte_o advances by one per tick.
- R9: reset_req_o stays high for exactly one cycle. After it, low_byte_o and the timeout stay frozen until a kick or reset.
- R10: When the idle-freeze select is 1 and idle_i is 1, ticks stop and low_byte_o holds. With the select at 0, idle_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| idle_i | input | 1 | Core idle indication, synchronous to clk_i |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Enable bit written |
| cfg_lock_i | input | 1 | Lock bit written (can only set) |
| cfg_clksel_i | input | 2 | Count-clock select written |
| cfg_idlesel_i | input | 1 | Idle-freeze select written |
| reload_we_i | input | 1 | Reload value write strobe |
| reload_i | input | 8 | Reload value (whole 256-tick periods) |
| kick_i | input | 1 | Timeout restart strobe |
| running_o | output | 1 | Watchdog active |
| lock_o | output | 1 | Lock state |
| clksel_o | output | 2 | Current count-clock select |
| idlesel_o | output | 1 | Current idle-freeze select |
| low_byte_o | output | 8 | Free-running low count |
| reset_req_o | output | 1 | One-cycle reset request on timeout |

## Verification
The assertions assume that idle_i and all strobes are synchronous to clk_i, and that every strobe is one cycle wide and driven between clock edges. The bench drives each input at the falling edge and releases each strobe one cycle later. It changes the clock select only while the watchdog is stopped, and it times kicks exactly only with the undivided clock, so the expected delay depends only on the observed low count and the reload value. Random reload values are kept small, which keeps each measured timeout short.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned LOW_W    = 8;
  localparam int unsigned RLD_W    = 8;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned DIV_SLOW = 12;
  localparam int unsigned DIV_MID  = 4;
  localparam int unsigned DIV_W    = $clog2(DIV_SLOW);

  typedef struct packed {
    logic             en;
    logic             lock;
    logic [SEL_W-1:0] clksel;
    logic             idlesel;
  } wdog_cfg_t;

  function automatic logic [DIV_W-1:0] div_limit(input logic [SEL_W-1:0] sel);
    case (sel)
      2'd0:    div_limit = DIV_W'(DIV_SLOW - 1);
      2'd1:    div_limit = DIV_W'(DIV_MID - 1);
      default: div_limit = '0;
    endcase
  endfunction
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] clksel,
  input  logic             idlesel,
  input  logic             idle,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] lim;
  logic             gate;

  assign lim  = div_limit(clksel);
  assign gate = idlesel & idle;
  assign tick = !gate && (cnt_q >= lim);

  always_comb begin
    cnt_d = cnt_q;
    if (!gate) begin
      if (cnt_q >= lim) cnt_d = '0;
      else              cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Frozen prescaler while gated (R10)
  assert_gate_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gate |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  wdog_cfg_t        wdata,
  output logic             run,
  output logic             lock,
  output logic [SEL_W-1:0] clksel,
  output logic             idlesel
);
  wdog_cfg_t cfg_q, cfg_d;

  assign run     = cfg_q.en | cfg_q.lock;
  assign lock    = cfg_q.lock;
  assign clksel  = cfg_q.clksel;
  assign idlesel = cfg_q.idlesel;

  always_comb begin
    cfg_d = cfg_q;
    if (we) begin
      cfg_d.en   = wdata.en;
      cfg_d.lock = cfg_q.lock | wdata.lock;
      if (!run) begin
        cfg_d.clksel  = wdata.clksel;
        cfg_d.idlesel = wdata.idlesel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.en      <= 1'b1;
      cfg_q.lock    <= 1'b0;
      cfg_q.clksel  <= '0;
      cfg_q.idlesel <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.lock |=> (cfg_q.lock && run));
  assert_sel_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ($stable(cfg_q.clksel) && $stable(cfg_q.idlesel)));
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned REM_W = LOW_W + RLD_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             kick,
  input  logic             reload_we,
  input  logic [RLD_W-1:0] reload,
  output logic [LOW_W-1:0] low,
  output logic             req
);
  localparam logic [REM_W-1:0] PERIOD = REM_W'(1) << LOW_W;

  logic [LOW_W-1:0] low_q, low_d;
  logic [RLD_W-1:0] rld_q, rld_d;
  logic [REM_W-1:0] rem_q, rem_d, arm;
  logic             halt_q, halt_d;
  logic             req_q, req_d;
  logic             adv;

  assign low = low_q;
  assign req = req_q;
  assign adv = tick && !halt_q;
  assign arm = (REM_W'(rld_q) << LOW_W) + (PERIOD - REM_W'(low_q));

  always_comb begin
    low_d  = low_q;
    rld_d  = reload_we ? reload : rld_q;
    rem_d  = rem_q;
    halt_d = halt_q;
    req_d  = 1'b0;
    if (adv) low_d = low_q + 1'b1;
    if (kick) begin
      rem_d  = arm;
      halt_d = 1'b0;
    end else if (adv && run && (rem_q != '0)) begin
      rem_d = rem_q - 1'b1;
      if (rem_q == REM_W'(1)) begin
        halt_d = 1'b1;
        req_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      rld_q  <= '0;
      rem_q  <= PERIOD;
      halt_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      low_q  <= low_d;
      rld_q  <= rld_d;
      rem_q  <= rem_d;
      halt_q <= halt_d;
      req_q  <= req_d;
    end
  end

  assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !kick) |=> $stable(low_q));
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rem_q == '0) && !kick) |=> (rem_q == '0));
endmodule

// File: rtl/wdog_lock_top.sv
module wdog_lock_top
  import wdog_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic             cfg_we_i,
  input  logic             cfg_en_i,
  input  logic             cfg_lock_i,
  input  logic [SEL_W-1:0] cfg_clksel_i,
  input  logic             cfg_idlesel_i,
  input  logic             reload_we_i,
  input  logic [RLD_W-1:0] reload_i,
  input  logic             kick_i,
  output logic             running_o,
  output logic             lock_o,
  output logic [SEL_W-1:0] clksel_o,
  output logic             idlesel_o,
  output logic [LOW_W-1:0] low_byte_o,
  output logic             reset_req_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_n;
  logic                   tick;
  wdog_cfg_t              wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n = sync_q[SYNC_STAGES-1];

  assign wdata.en      = cfg_en_i;
  assign wdata.lock    = cfg_lock_i;
  assign wdata.clksel  = cfg_clksel_i;
  assign wdata.idlesel = cfg_idlesel_i;

  wdog_ctrl u_ctrl (
    .clk(clk_i), .rst_n(rst_n), .we(cfg_we_i), .wdata(wdata),
    .run(running_o), .lock(lock_o), .clksel(clksel_o), .idlesel(idlesel_o)
  );

  wdog_prescale u_pre (
    .clk(clk_i), .rst_n(rst_n), .clksel(clksel_o), .idlesel(idlesel_o),
    .idle(idle_i), .tick(tick)
  );

  wdog_core u_core (
    .clk(clk_i), .rst_n(rst_n), .tick(tick), .run(running_o), .kick(kick_i),
    .reload_we(reload_we_i), .reload(reload_i), .low(low_byte_o), .req(reset_req_o)
  );

  assert_req_only_running_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reset_req_o && !$past(kick_i)) |-> $past(running_o));
endmodule

// File: tb/wdog_lock_top_tb.sv
module wdog_lock_top_tb;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       idle_i, cfg_we_i, cfg_en_i, cfg_lock_i, cfg_idlesel_i;
  logic [1:0] cfg_clksel_i;
  logic       reload_we_i, kick_i;
  logic [7:0] reload_i;
  logic       running_o, lock_o, idlesel_o, reset_req_o;
  logic [1:0] clksel_o;
  logic [7:0] low_byte_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  wdog_lock_top u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .idle_i(idle_i), .cfg_we_i(cfg_we_i),
    .cfg_en_i(cfg_en_i), .cfg_lock_i(cfg_lock_i), .cfg_clksel_i(cfg_clksel_i),
    .cfg_idlesel_i(cfg_idlesel_i), .reload_we_i(reload_we_i), .reload_i(reload_i),
    .kick_i(kick_i), .running_o(running_o), .lock_o(lock_o), .clksel_o(clksel_o),
    .idlesel_o(idlesel_o), .low_byte_o(low_byte_o), .reset_req_o(reset_req_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, act=%0d exp<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int tmo(input int rld, input int low);
    return 256 * rld + (256 - low);
  endfunction

  task automatic cfg(input logic en, input logic lk, input logic [1:0] sel, input logic isel);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_en_i = en; cfg_lock_i = lk; cfg_clksel_i = sel; cfg_idlesel_i = isel;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic set_reload(input logic [7:0] v);
    @(negedge clk);
    reload_we_i = 1'b1; reload_i = v;
    @(negedge clk);
    reload_we_i = 1'b0;
  endtask

  // kick at the next edge, returns low byte seen at that edge
  task automatic kick(output int low_at);
    @(negedge clk);
    kick_i = 1'b1;
    low_at = low_byte_o;
    @(negedge clk);
    kick_i = 1'b0;
  endtask

  task automatic wait_req(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(negedge clk);
      n = n + 1;
      if (reset_req_o) break;
    end
  endtask

  task automatic count_low(input int span, output int delta);
    int a;
    @(negedge clk);
    a = low_byte_o;
    repeat (span) @(negedge clk);
    delta = (low_byte_o - a + 256) % 256;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int n, l, d, seed, seen;
    seed = 32'h5eed;
    void'($urandom(seed));
    rst_ni = 1'b0; idle_i = 0; cfg_we_i = 0; cfg_en_i = 0; cfg_lock_i = 0;
    cfg_clksel_i = 0; cfg_idlesel_i = 0; reload_we_i = 0; reload_i = 0; kick_i = 0;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 running", running_o, 1);
    chk("R1 lock", lock_o, 0);
    chk("R1 clksel", clksel_o, 0);
    chk("R1 idlesel", idlesel_o, 0);
    chk("R1 low", low_byte_o, 0);
    chk("R1 req", reset_req_o, 0);

    // R2 default timeout
    rst_ni = 1'b1;
    wait_req(5000, n);
    chk("R2 default timeout edges", n, 3074);
    // R9 single pulse and freeze
    @(negedge clk);
    chk("R9 pulse one cycle", reset_req_o, 0);
    l = low_byte_o;
    repeat (40) @(negedge clk);
    chk("R9 low frozen after expiry", low_byte_o, l);

    // R7 ignored while running
    cfg(1'b1, 1'b0, 2'd2, 1'b1);
    chk("R7 clksel ignored", clksel_o, 0);
    chk("R7 idlesel ignored", idlesel_o, 0);

    // R5 disable, then selects accepted
    cfg(1'b0, 1'b0, 2'd2, 1'b0);
    chk("R5 stopped", running_o, 0);
    cfg(1'b0, 1'b0, 2'd2, 1'b0);
    chk("R7 clksel accepted when stopped", clksel_o, 2);
    kick(l);
    wait_req(600, n);
    chk("R5 no request while disabled", n, 600);
    count_low(30, d);
    chk("R5 low advances while disabled", d, 30);

    // R8 encodings
    count_low(24, d); chk("R8 sel2 rate", d, 24);
    cfg(1'b0, 1'b0, 2'd1, 1'b0);
    count_low(24, d); chk("R8 sel1 rate", d, 6);
    cfg(1'b0, 1'b0, 2'd0, 1'b0);
    count_low(24, d); chk("R8 sel0 rate", d, 2);
    cfg(1'b0, 1'b0, 2'd3, 1'b0);
    count_low(24, d); chk("R8 sel3 rate", d, 24);

    // R10 idle freeze
    cfg(1'b0, 1'b0, 2'd2, 1'b1);
    idle_i = 1'b1;
    count_low(10, d); chk("R10 frozen in idle", d, 0);
    idle_i = 1'b0;
    count_low(10, d); chk("R10 runs when not idle", d, 10);
    cfg(1'b0, 1'b0, 2'd2, 1'b0);
    idle_i = 1'b1;
    count_low(10, d); chk("R10 idle ignored with select 0", d, 10);
    idle_i = 1'b0;

    // R3 random reloads and kick points
    cfg(1'b1, 1'b0, 2'd2, 1'b0);
    for (int i = 0; i < 8; i++) begin
      int r;
      int w;
      r = $urandom % 4;
      w = $urandom % 300;
      set_reload(8'(r));
      repeat (w) @(negedge clk);
      kick(l);
      wait_req(2000, n);
      chk($sformatf("R3 timeout reload=%0d low=%0d", r, l), n, tmo(r, l));
    end

    // R4 regular kicking prevents request
    set_reload(8'd1);
    seen = 0;
    for (int k = 0; k < 12; k++) begin
      kick(l);
      repeat (200) begin
        @(negedge clk);
        if (reset_req_o) seen = 1;
      end
    end
    chk("R4 no request while kicked", seen, 0);
    kick(l);
    wait_req(2000, n);
    chk("R4 request after kicks stop", n, tmo(1, l));

    // R6 lock
    cfg(1'b0, 1'b1, 2'd2, 1'b0);
    chk("R6 lock set", lock_o, 1);
    chk("R6 running with enable 0", running_o, 1);
    cfg(1'b0, 1'b0, 2'd0, 1'b0);
    chk("R6 lock stays", lock_o, 1);
    chk("R6 still running", running_o, 1);
    chk("R7 clksel ignored while locked", clksel_o, 2);
    kick(l);
    wait_req(2000, n);
    chk("R6 locked watchdog still times out", n, tmo(1, l));
    do_reset();
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 lock cleared by reset", lock_o, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule